// File: doc/BRIEF.md
# Indirect Memory Access Window

This block lets a host reach an internal word-organised memory that sits outside its address map. The host first loads a 32-bit target address into a pointer register, then performs byte, halfword or word transfers through a data port. Each data-port transfer becomes exactly one access on the internal memory port, at the word that holds the stored pointer. The pointer never advances by itself, so streaming many transfers to one location (a FIFO-like register, for example) needs only one pointer load.

Which bytes of the word are touched comes from the offset of the data-port access, not from the low bits of the pointer. A byte transfer picks one of four lanes and a halfword transfer picks the low or high pair. A pointer-follow operation supports linked tables. It adds a host-supplied offset to the pointer, reads the word there, loads that word into the pointer and returns it to the host.

Top module: `iwin_top`

## Requirements
- R1: After reset the pointer register reads as 0, `host_rvalid` is 0 and `mem_req` is 0.
- R2: A pointer write (`host_op`=0, `host_we`=1) loads all 32 bits of `host_wdata`. A pointer read (`host_op`=0, `host_we`=0) returns that value on `host_rdata` with `host_rvalid` high in the following cycle.
- R3: A data-port transfer (`host_op`=1) drives `mem_req` high in the same cycle for exactly that cycle. `mem_we` equals `host_we` and `mem_addr` equals pointer bits [WORD_AW+1:2].
- R4: A byte transfer (`host_size`=0) drives `mem_be` one-hot with bit `host_ofs` set. On a write the byte appears in lane `host_ofs` of `mem_wdata`.
- R5: A halfword transfer (`host_size`=1) drives `mem_be`=4'b0011 when `host_ofs[1]`=0 and 4'b1100 when it is 1; `host_ofs[0]` has no effect.
- R6: A word transfer (`host_size`=2, or the unused code 3) drives `mem_be`=4'b1111 whatever `host_ofs` is.
- R7: A data-port read returns the selected lane, zero-extended, on `host_rdata` with `host_rvalid` high one cycle after the `mem_req` cycle.
- R8: Data-port transfers never change the pointer. Back-to-back transfers all hit the same `mem_addr`.
- R9: A pointer-follow (`host_op`=2) reads the whole word at (pointer + `host_wdata`) with the low two bits of the sum dropped. It loads the returned word into the pointer and returns it on `host_rdata` one cycle later.
- R10: The low two bits of the pointer do not affect `mem_addr` or `mem_be` on data-port transfers.
- R11: Pointer reads, pointer writes and the unused op code 3 start no memory access. The unused code also returns no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host transfer valid this cycle |
| host_op | input | 2 | 0 pointer, 1 data port, 2 pointer-follow, 3 unused |
| host_we | input | 1 | 1 write, 0 read (pointer and data port) |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_ofs | input | 2 | Data-port byte offset |
| host_wdata | input | 32 | Write data, pointer value or follow offset |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid |
| mem_req | output | 1 | Internal memory strobe |
| mem_we | output | 1 | Internal memory write |
| mem_addr | output | WORD_AW | Internal word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data, replicated across lanes |
| mem_rdata | input | 32 | Read data, valid in the strobe cycle |

## Verification
The bench deliberately sets the pointer to an unaligned value. A design that let its low bits leak would hit the wrong word or shift the byte enables. Halfword transfers at offset 3 and word transfers at offset 1 catch lane decoders that use the raw offset rather than only the bits that matter. Long runs of reads at one pointer, followed by a pointer readback, expose any hidden increment. The pointer-follow case uses a base and offset whose low bits carry into the word address. A design that dropped that carry, or returned the word without loading it as the new pointer, would read the wrong entry or leave the old address in place.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

  typedef enum logic [1:0] {
    OP_PTR   = 2'd0,
    OP_DATA  = 2'd1,
    OP_CHASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  // Byte enables for a data-port transfer of a given size and offset.
  function automatic logic [3:0] lane_mask(size_e sz, logic [1:0] ofs);
    case (sz)
      SZ_BYTE: return 4'b0001 << ofs;
      SZ_HALF: return ofs[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // Write data copied into every lane; the enables pick the live one.
  function automatic logic [31:0] lane_spread(size_e sz, logic [31:0] d);
    case (sz)
      SZ_BYTE: return {4{d[7:0]}};
      SZ_HALF: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  // Extract and zero-extend the addressed lane of a read word.
  function automatic logic [31:0] lane_pick(size_e sz, logic [1:0] ofs, logic [31:0] r);
    logic [31:0] sh;
    sh = r >> {ofs, 3'b000};
    case (sz)
      SZ_BYTE: return {24'h0, sh[7:0]};
      SZ_HALF: return {16'h0, (ofs[1] ? r[31:16] : r[15:0])};
      default: return r;
    endcase
  endfunction

endpackage

// File: rtl/iwin_ptr.sv
module iwin_ptr #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_val,
  input  logic             chase_en,
  input  logic [PTR_W-1:0] chase_val,
  output logic [PTR_W-1:0] ptr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_q <= '0;
    else if (wr_en)    ptr_q <= wr_val;
    else if (chase_en) ptr_q <= chase_val;
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !chase_en) |=> $stable(ptr_q)) else $error("pointer moved"); // R8
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr_q == $past(wr_val))) else $error("pointer load lost"); // R2
  AST_CHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (chase_en && !wr_en) |=> (ptr_q == $past(chase_val))) else $error("follow load lost"); // R9

endmodule

// File: rtl/iwin_lanes.sv
module iwin_lanes
  import iwin_pkg::*;
#(
  parameter int WORD_AW = 6,
  localparam int BYTE_AW = WORD_AW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_fire,
  input  logic               chase_fire,
  input  logic               we,
  input  size_e              size,
  input  logic [1:0]         ofs,
  input  logic [31:0]        wdata,
  input  logic [BYTE_AW-1:0] ptr_lo,
  input  logic [BYTE_AW-1:0] chase_ofs,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [3:0]         mem_be,
  output logic [31:0]        mem_wdata
);

  logic [BYTE_AW-1:0] chase_sum;
  logic               unused_sum_lo;

  assign chase_sum     = ptr_lo + chase_ofs;
  assign unused_sum_lo = ^chase_sum[1:0];

  always_comb begin
    mem_req   = data_fire | chase_fire;
    mem_we    = data_fire & we;
    mem_addr  = chase_fire ? chase_sum[BYTE_AW-1:2] : ptr_lo[BYTE_AW-1:2];
    mem_wdata = lane_spread(size, wdata);
    if (chase_fire)     mem_be = 4'b1111;
    else if (data_fire) mem_be = lane_mask(size, ofs);
    else                mem_be = 4'b0000;
  end

  AST_BYTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && size == SZ_BYTE) |-> ($countones(mem_be) == 1)) else $error("byte lanes"); // R4
  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && size == SZ_HALF) |-> (mem_be == 4'b0011 || mem_be == 4'b1100)) else $error("half lanes"); // R5
  AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (size == SZ_WORD || chase_fire)) |-> (mem_be == 4'b1111)) else $error("word lanes"); // R6

endmodule

// File: rtl/iwin_rdpath.sv
module iwin_rdpath
  import iwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_rd_fire,
  input  logic        ptr_rd_fire,
  input  size_e       size,
  input  logic [1:0]  ofs,
  input  logic [31:0] mem_rdata,
  input  logic [31:0] ptr_q,
  output logic [31:0] host_rdata,
  output logic        host_rvalid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= mem_rd_fire | ptr_rd_fire;
      if (ptr_rd_fire)      host_rdata <= ptr_q;
      else if (mem_rd_fire) host_rdata <= lane_pick(size, ofs, mem_rdata);
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_fire |=> host_rvalid) else $error("read data missing"); // R7
  AST_RVALID_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_fire && !ptr_rd_fire) |=> !host_rvalid) else $error("spurious read data"); // R11

endmodule

// File: rtl/iwin_top.sv
module iwin_top
  import iwin_pkg::*;
#(
  parameter int WORD_AW = 6,
  localparam int BYTE_AW = WORD_AW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic [1:0]         host_op,
  input  logic               host_we,
  input  logic [1:0]         host_size,
  input  logic [1:0]         host_ofs,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               host_rvalid,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [3:0]         mem_be,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata
);

  op_e         op;
  size_e       size;
  size_e       rd_size;
  logic        ptr_wr_fire;
  logic        ptr_rd_fire;
  logic        data_fire;
  logic        chase_fire;
  logic        mem_rd_fire;
  logic [31:0] ptr_q;

  assign op          = op_e'(host_op);
  assign size        = size_e'(host_size);
  assign ptr_wr_fire = host_req && op == OP_PTR && host_we;
  assign ptr_rd_fire = host_req && op == OP_PTR && !host_we;
  assign data_fire   = host_req && op == OP_DATA;
  assign chase_fire  = host_req && op == OP_CHASE;
  assign mem_rd_fire = (data_fire && !host_we) || chase_fire;
  assign rd_size     = chase_fire ? SZ_WORD : size;

  iwin_ptr #(.PTR_W(32)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ptr_wr_fire),
    .wr_val    (host_wdata),
    .chase_en  (chase_fire),
    .chase_val (mem_rdata),
    .ptr_q     (ptr_q)
  );

  iwin_lanes #(.WORD_AW(WORD_AW)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_fire  (data_fire),
    .chase_fire (chase_fire),
    .we         (host_we),
    .size       (size),
    .ofs        (host_ofs),
    .wdata      (host_wdata),
    .ptr_lo     (ptr_q[BYTE_AW-1:0]),
    .chase_ofs  (host_wdata[BYTE_AW-1:0]),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata)
  );

  iwin_rdpath u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd_fire (mem_rd_fire),
    .ptr_rd_fire (ptr_rd_fire),
    .size        (rd_size),
    .ofs         (host_ofs),
    .mem_rdata   (mem_rdata),
    .ptr_q       (ptr_q),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  AST_PTR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && (op == OP_PTR || op == OP_NONE)) |-> !mem_req) else $error("pointer op hit memory"); // R11
  AST_DATA_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && !$past(mem_req)) |-> mem_req) else $error("data op no strobe"); // R3
  AST_DATA_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(data_fire) && data_fire) |-> $stable(mem_addr)) else $error("address advanced"); // R8

endmodule

// File: tb/tb_iwin_top.sv
`timescale 1ns/1ps
module tb_iwin_top;

  localparam int WA = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0;
  logic [1:0]    host_op = 2'd3;
  logic          host_we = 1'b0;
  logic [1:0]    host_size = 2'd0;
  logic [1:0]    host_ofs = 2'd0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          host_rvalid;
  logic          mem_req;
  logic          mem_we;
  logic [WA-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;

  logic [31:0] marr [0:(1<<WA)-1];
  logic [31:0] shadow [0:(1<<WA)-1];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  logic          s_req, s_we;
  logic [WA-1:0] s_addr;
  logic [3:0]    s_be;
  logic [31:0]   s_wdata;

  always #4 clk = ~clk;

  iwin_top #(.WORD_AW(WA)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
    .host_we(host_we), .host_size(host_size), .host_ofs(host_ofs),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Internal memory model: asynchronous read, lane-enabled write.
  assign mem_rdata = marr[mem_addr];
  always @(posedge clk) begin
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) marr[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] want_be(input logic [1:0] sz, input logic [1:0] ofs);
    if (sz == 2'd0) return (ofs == 0) ? 4'h1 : (ofs == 1) ? 4'h2 : (ofs == 2) ? 4'h4 : 4'h8;
    if (sz == 2'd1) return ofs[1] ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  function automatic logic [31:0] want_rd(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] ofs);
    if (sz == 2'd0) begin
      case (ofs)
        2'd0: return {24'h0, w[7:0]};
        2'd1: return {24'h0, w[15:8]};
        2'd2: return {24'h0, w[23:16]};
        default: return {24'h0, w[31:24]};
      endcase
    end
    if (sz == 2'd1) return ofs[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    return w;
  endfunction

  // Scoreboard monitor: every returned read is compared with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rvalid", host_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic we, input logic [1:0] sz,
                       input logic [1:0] ofs, input logic [31:0] wd);
    @(negedge clk);
    host_req = 1'b1; host_op = op; host_we = we; host_size = sz;
    host_ofs = ofs; host_wdata = wd;
    #1;
    s_req = mem_req; s_we = mem_we; s_addr = mem_addr; s_be = mem_be; s_wdata = mem_wdata;
  endtask

  task automatic idle();
    @(negedge clk);
    host_req = 1'b0; host_op = 2'd3;
    #1;
  endtask

  task automatic set_ptr(input logic [31:0] p);
    do_op(2'd0, 1'b1, 2'd2, 2'd0, p);
    check(s_req == 1'b0, "R11 pointer write strobe", {31'h0, s_req}, 32'h0);
  endtask

  task automatic read_ptr(input logic [31:0] exp, input string tag);
    do_op(2'd0, 1'b0, 2'd2, 2'd0, 32'h0);
    check(s_req == 1'b0, "R11 pointer read strobe", {31'h0, s_req}, 32'h0);
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic data_wr(input logic [31:0] ptr, input logic [1:0] sz, input logic [1:0] ofs,
                         input logic [31:0] d, input string tag);
    logic [3:0]    be;
    logic [WA-1:0] wa;
    be = want_be(sz, ofs);
    wa = ptr[WA+1:2];
    do_op(2'd1, 1'b1, sz, ofs, d);
    check(s_req && s_we && s_addr == wa, {tag, " R3 strobe/addr"}, {s_req, s_we, 24'h0, s_addr}, {2'b11, 24'h0, wa});
    check(s_be == be, {tag, " enables"}, {28'h0, s_be}, {28'h0, be});
    for (int b = 0; b < 4; b++)
      if (be[b]) begin
        logic [7:0] lane_exp;
        lane_exp = (sz == 2'd0) ? d[7:0] : (sz == 2'd1) ? d[8*(b%2) +: 8] : d[8*b +: 8];
        check(s_wdata[8*b +: 8] == lane_exp, {tag, " lane data"}, {24'h0, s_wdata[8*b +: 8]}, {24'h0, lane_exp});
        shadow[wa][8*b +: 8] = lane_exp;
      end
  endtask

  task automatic data_rd(input logic [31:0] ptr, input logic [1:0] sz, input logic [1:0] ofs, input string tag);
    logic [WA-1:0] wa;
    wa = ptr[WA+1:2];
    do_op(2'd1, 1'b0, sz, ofs, 32'h0);
    check(s_req && !s_we && s_addr == wa, "R8 R10 read addr", {s_req, s_we, 24'h0, s_addr}, {2'b10, 24'h0, wa});
    exp_q.push_back(want_rd(shadow[wa], sz, ofs)); tag_q.push_back(tag);
  endtask

  initial begin
    for (int i = 0; i < (1<<WA); i++) begin marr[i] = '0; shadow[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check(host_rvalid == 1'b0, "R1 rvalid after reset", {31'h0, host_rvalid}, 32'h0);
    check(mem_req == 1'b0, "R1 mem_req after reset", {31'h0, mem_req}, 32'h0);
    read_ptr(32'h0, "R1 pointer after reset");

    // Unaligned pointer; low bits must not matter (R10).
    set_ptr(32'hF000_0013);
    read_ptr(32'hF000_0013, "R2 pointer readback");
    data_wr(32'h13, 2'd2, 2'd1, 32'hA1B2_C3D4, "R6 word write ofs1");
    data_rd(32'h13, 2'd3, 2'd2, "R7 word read code3");

    // Byte lanes by offset (R4), then back-to-back byte reads (R8).
    for (int i = 0; i < 4; i++) data_wr(32'h13, 2'd0, i[1:0], 32'h10 + i, "R4 byte write");
    for (int i = 0; i < 4; i++) data_rd(32'h13, 2'd0, i[1:0], "R7 byte read");
    read_ptr(32'hF000_0013, "R8 pointer unchanged");

    // Halfword pairs; offset bit 0 ignored (R5).
    data_wr(32'h13, 2'd1, 2'd3, 32'h0000_BEEF, "R5 half write ofs3");
    data_wr(32'h13, 2'd1, 2'd0, 32'hFFFF_1234, "R5 half write ofs0");
    data_rd(32'h13, 2'd1, 2'd2, "R5 half read ofs2");
    data_rd(32'h13, 2'd1, 2'd1, "R5 half read ofs1");
    data_rd(32'h13, 2'd2, 2'd0, "R7 word after halves");

    // Pointer-follow: table entry at word 10 holds 0x84 (R9).
    set_ptr(32'h28);
    data_wr(32'h28, 2'd2, 2'd0, 32'h0000_0084, "R9 table entry");
    set_ptr(32'h21);
    do_op(2'd2, 1'b0, 2'd0, 2'd0, 32'h7);
    check(s_req && !s_we && s_addr == 6'd10 && s_be == 4'hF, "R9 follow access",
          {s_req, s_we, 20'h0, s_be, s_addr}, {2'b10, 20'h0, 4'hF, 6'd10});
    exp_q.push_back(32'h84); tag_q.push_back("R9 follow data");
    read_ptr(32'h84, "R9 pointer loaded");
    data_wr(32'h84, 2'd2, 2'd0, 32'h0000_55AA, "R9 write via followed pointer");
    data_rd(32'h84, 2'd2, 2'd0, "R9 read via followed pointer");

    // Unused op code: no strobe, no read data (R11).
    do_op(2'd3, 1'b0, 2'd2, 2'd0, 32'h0);
    check(s_req == 1'b0, "R11 unused op strobe", {31'h0, s_req}, 32'h0);
    idle();
    repeat (3) idle();
    check(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule